// File: doc/BRIEF.md
# Square-Wave Smoothing Biquad Cascade

This block is a fixed-point low-pass filter that works on sampled data. It turns a bipolar square wave, whose samples are +1 and -1, into a waveform close to a sine. When the upstream source is idle it receives a steady zero. The filter is built from two second-order sections in transposed form. Each section has feedforward taps of 1, 2 and 1 and its own pair of fixed feedback gains. Between the two sections sits a stage that scales the first section's result by one eighth and holds it for one sample. The final result passes through one more register before it reaches the output.

Samples are only accepted on clock edges where the sample-enable strobe is high, so the filter can run at a sample rate well below the clock. All recursion is done in a wide internal format. Only the value written to the output port is rounded back to 16 bits and saturated.

Top module: `biquad_cascade`

## Requirements
- R1: A synchronous reset clears both sections, the inter-stage register, the output and the valid flag. In the cycle after reset the output reads 0 and valid is low. Feeding zero samples after a reset keeps the output at exactly 0.
- R2: Input and output samples are signed 16-bit two's complement values with 13 fraction bits, so +1.0 is 8192. Every output lies within 2 LSB of an exact-arithmetic model that uses the same coefficients, each rounded to the nearest multiple of 1/8192.
- R3: The first section, with input u and output y = u + q2, updates as q1' = u - 0.75*y and q2' = q1 + 2*u + 0.5625*y. Its two state registers start at zero.
- R4: The second section has the same structure but feedback gains of -0.3438 (stored as -2816/8192) into q1 and 1.0 into q2.
- R5: The first section's output is multiplied by 0.125 and held for one accepted sample before it drives the second section. After a reset, a single +1.0 impulse gives 0 as the output for its own sample and exactly 1024 for the next sample.
- R6: The output register loads the second section's rounded result on each accepted sample. The valid flag is high in exactly the cycle after a clock edge with sample-enable high, and low otherwise.
- R7: While sample-enable is low, every state register and the output hold their values, and the input sample has no effect on later outputs.
- R8: Results above 32767 or below -32768 are clamped to those limits. They never wrap to the opposite sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleEn | input | 1 | Accept the input sample on this edge |
| sampleIn | input | 16 | Signed input sample, 13 fraction bits |
| sampleOut | output | 16 | Signed filtered sample, 13 fraction bits |
| outValid | output | 1 | High for one cycle after each accepted sample |

## Verification
Some behaviours are checked by assertions on every cycle:
- each section's state and the output stay frozen while the strobe is low;
- all registers read zero after a reset;
- the valid flag follows the strobe by one cycle;
- a non-negative section result never turns into a negative output.

The numeric behaviour can only be shown by the bench's scenarios. These cover the two recurrences, the one-eighth inter-stage gain with its extra sample of delay, rounding accuracy against a floating-point model, and clamping at both rails. The scenarios use impulse, step, square-wave, full-scale and gapped random inputs.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic advance;  // accept one sample: all registers step
    logic clear;    // synchronous clear of every register
  } iirStrobe_t;
endpackage

// File: rtl/coef_mul.sv
// Multiplies a wide accumulator value by a fixed signed coefficient and
// rounds the product back to the accumulator's fraction position.
module coef_mul #(
  parameter int ACC_W     = 32,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 13,
  parameter int COEF      = 0
) (
  input  logic signed [ACC_W-1:0] operand,
  output logic signed [ACC_W-1:0] product
);
  localparam int PROD_W = ACC_W + COEF_W;
  localparam logic signed [COEF_W-1:0] COEF_Q = COEF_W'(COEF);
  localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) <<< (COEF_FRAC - 1);

  logic signed [PROD_W-1:0] wideProd;
  logic signed [PROD_W-1:0] biased;

  always_comb begin
    wideProd = PROD_W'(operand) * PROD_W'(COEF_Q);
    biased   = wideProd + HALF_LSB;
    product  = ACC_W'(biased >>> COEF_FRAC);
  end
endmodule

// File: rtl/biquad_sect.sv
// Transposed second-order section with fixed 1,2,1 feedforward taps.
module biquad_sect
  import biquad_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 13,
  parameter int FB_NEAR   = 0,   // feedback into the first state node
  parameter int FB_FAR    = 0    // feedback into the second state node
) (
  input  logic                    clk,
  input  iirStrobe_t              strb,
  input  logic signed [ACC_W-1:0] xIn,
  output logic signed [ACC_W-1:0] yOut
);
  localparam int NUM_FB = 2;
  localparam int FB_TAPS [NUM_FB] = '{FB_NEAR, FB_FAR};

  logic signed [ACC_W-1:0] nodeA, nodeB;
  logic signed [ACC_W-1:0] fbTerm [NUM_FB];
  logic signed [ACC_W-1:0] nodeANext, nodeBNext;

  assign yOut = xIn + nodeB;

  for (genvar g = 0; g < NUM_FB; g++) begin : g_fb
    coef_mul #(
      .ACC_W(ACC_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .COEF(FB_TAPS[g])
    ) u_fb (
      .operand(yOut),
      .product(fbTerm[g])
    );
  end

  always_comb begin
    nodeANext = xIn + fbTerm[0];
    nodeBNext = nodeA + (xIn <<< 1) + fbTerm[1];
  end

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      nodeA <= '0;
      nodeB <= '0;
    end else if (strb.advance) begin
      nodeA <= nodeANext;
      nodeB <= nodeBNext;
    end
  end

  // R7
  sect_hold_chk: assert property (@(posedge clk) disable iff (strb.clear)
    !strb.advance |=> ($stable(nodeA) && $stable(nodeB)));

  // R1
  sect_clear_chk: assert property (@(posedge clk) disable iff (strb.clear)
    $past(strb.clear) |-> (nodeA == '0 && nodeB == '0));
endmodule

// File: rtl/iir_ctrl.sv
// Turns the reset and sample strobe into datapath strobes and the valid flag.
module iir_ctrl
  import biquad_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sampleEn,
  output iirStrobe_t strb,
  output logic       outValid
);
  always_comb begin
    strb.clear   = rst;
    strb.advance = sampleEn & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= sampleEn;
  end

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    sampleEn |=> outValid);

  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sampleEn |=> !outValid);
endmodule

// File: rtl/iir_datapath.sv
// Two cascaded sections, the scaled inter-stage register and the output stage.
module iir_datapath
  import biquad_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DATA_FRAC = 13,
  parameter int ACC_W     = 32,
  parameter int ACC_FRAC  = 20,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 13,
  parameter int A_FB_NEAR = -6144,
  parameter int A_FB_FAR  = 4608,
  parameter int B_FB_NEAR = -2816,
  parameter int B_FB_FAR  = 8192,
  parameter int MID_GAIN  = 1024
) (
  input  logic                     clk,
  input  iirStrobe_t               strb,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [DATA_W-1:0] sampleOut
);
  localparam int ALIGN = ACC_FRAC - DATA_FRAC;
  localparam logic signed [ACC_W-1:0] ROUND_HALF = ACC_W'(1) <<< (ALIGN - 1);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] SAT_LO = ACC_W'(-(64'sd1 <<< (DATA_W - 1)));

  logic signed [ACC_W-1:0] inWide;
  logic signed [ACC_W-1:0] yA, yB;
  logic signed [ACC_W-1:0] scaledA;
  logic signed [ACC_W-1:0] midReg;
  logic signed [ACC_W-1:0] roundedB, shiftedB;
  logic signed [DATA_W-1:0] narrowB;

  assign inWide = ACC_W'(sampleIn) <<< ALIGN;

  biquad_sect #(
    .ACC_W(ACC_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
    .FB_NEAR(A_FB_NEAR), .FB_FAR(A_FB_FAR)
  ) u_sectA (
    .clk(clk), .strb(strb), .xIn(inWide), .yOut(yA)
  );

  coef_mul #(
    .ACC_W(ACC_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .COEF(MID_GAIN)
  ) u_midGain (
    .operand(yA), .product(scaledA)
  );

  biquad_sect #(
    .ACC_W(ACC_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
    .FB_NEAR(B_FB_NEAR), .FB_FAR(B_FB_FAR)
  ) u_sectB (
    .clk(clk), .strb(strb), .xIn(midReg), .yOut(yB)
  );

  // Round to the output fraction, then clamp to the output range.
  always_comb begin
    roundedB = yB + ROUND_HALF;
    shiftedB = roundedB >>> ALIGN;
    if (shiftedB > SAT_HI)      narrowB = DATA_W'(SAT_HI);
    else if (shiftedB < SAT_LO) narrowB = DATA_W'(SAT_LO);
    else                        narrowB = DATA_W'(shiftedB);
  end

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      midReg    <= '0;
      sampleOut <= '0;
    end else if (strb.advance) begin
      midReg    <= scaledA;
      sampleOut <= narrowB;
    end
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (strb.clear)
    !strb.advance |=> ($stable(sampleOut) && $stable(midReg)));

  // R1
  out_clear_chk: assert property (@(posedge clk) disable iff (strb.clear)
    $past(strb.clear) |-> (sampleOut == '0 && midReg == '0));

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (strb.clear)
    (strb.advance && !yB[ACC_W-1]) |=> !sampleOut[DATA_W-1]);
endmodule

// File: rtl/biquad_cascade.sv
module biquad_cascade
  import biquad_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DATA_FRAC = 13,
  parameter int ACC_W     = 32,
  parameter int ACC_FRAC  = 20,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 13,
  parameter int A_FB_NEAR = -6144,
  parameter int A_FB_FAR  = 4608,
  parameter int B_FB_NEAR = -2816,
  parameter int B_FB_FAR  = 8192,
  parameter int MID_GAIN  = 1024
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sampleEn,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [DATA_W-1:0] sampleOut,
  output logic                     outValid
);
  iirStrobe_t strb;

  iir_ctrl u_ctrl (
    .clk(clk), .rst(rst), .sampleEn(sampleEn), .strb(strb), .outValid(outValid)
  );

  iir_datapath #(
    .DATA_W(DATA_W), .DATA_FRAC(DATA_FRAC), .ACC_W(ACC_W), .ACC_FRAC(ACC_FRAC),
    .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
    .A_FB_NEAR(A_FB_NEAR), .A_FB_FAR(A_FB_FAR),
    .B_FB_NEAR(B_FB_NEAR), .B_FB_FAR(B_FB_FAR), .MID_GAIN(MID_GAIN)
  ) u_dp (
    .clk(clk), .strb(strb), .sampleIn(sampleIn), .sampleOut(sampleOut)
  );
endmodule

// File: tb/biquad_cascade_tb.sv
module biquad_cascade_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TOL = 2;

  logic clk = 1'b0;
  logic rst;
  logic sampleEn;
  logic signed [15:0] sampleIn;
  logic signed [15:0] sampleOut;
  logic outValid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int lastOut = 0;

  real cA0, cA1, cB0, cB1, cG;
  real ra1, ra2, rmid, rb1, rb2;

  always #(CLK_PERIOD/2) clk = ~clk;

  biquad_cascade u_dut (
    .clk(clk), .rst(rst), .sampleEn(sampleEn), .sampleIn(sampleIn),
    .sampleOut(sampleOut), .outValid(outValid)
  );

  function automatic real qc(real x);
    return $floor(x * 8192.0 + 0.5) / 8192.0;
  endfunction

  task automatic check(string tag, int act, int exp, int tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic refReset();
    ra1 = 0.0; ra2 = 0.0; rmid = 0.0; rb1 = 0.0; rb2 = 0.0;
  endtask

  task automatic refPush(input real u, output int expOut);
    real yA, yB, v;
    real na1, na2, nb1, nb2;
    yA  = u + ra2;
    yB  = rmid + rb2;
    na1 = u + cA0 * yA;
    na2 = ra1 + 2.0 * u + cA1 * yA;
    nb1 = rmid + cB0 * yB;
    nb2 = rb1 + 2.0 * rmid + cB1 * yB;
    ra1 = na1; ra2 = na2; rb1 = nb1; rb2 = nb2;
    rmid = cG * yA;
    v = $floor(yB * 8192.0 + 0.5);
    if (v > 32767.0)  v = 32767.0;
    if (v < -32768.0) v = -32768.0;
    expOut = $rtoi(v);
  endtask

  // Called at a negedge; returns at the next negedge after the output settles.
  task automatic push(input int val, input string tag, input int tol);
    int e;
    sampleIn = 16'(val);
    sampleEn = 1'b1;
    @(negedge clk);
    refPush(real'(val) / 8192.0, e);
    check({tag, " valid (R6)"}, int'(outValid), 1, 0);
    check(tag, int'(sampleOut), e, tol);
    lastOut = int'(sampleOut);
  endtask

  task automatic idle(input string tag);
    sampleEn = 1'b0;
    sampleIn = 16'($urandom);
    @(negedge clk);
    check({tag, " valid low (R6)"}, int'(outValid), 0, 0);
    check({tag, " hold (R7)"}, int'(sampleOut), lastOut, 0);
  endtask

  task automatic doReset();
    rst = 1'b1;
    sampleEn = 1'b1;
    sampleIn = 16'sd8192;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset output", int'(sampleOut), 0, 0);
    check("R1 reset valid", int'(outValid), 0, 0);
    rst = 1'b0;
    sampleEn = 1'b0;
    sampleIn = '0;
    refReset();
    lastOut = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seedv;
    int r;
    seedv = 20240611;
    r = int'($urandom(seedv));
    cA0 = qc(-0.75);   cA1 = qc(0.5625);
    cB0 = qc(-0.3438); cB1 = qc(1.0);
    cG  = qc(0.125);
    refReset();

    rst = 1'b1; sampleEn = 1'b0; sampleIn = '0;
    repeat (3) @(negedge clk);
    check("R1 initial output", int'(sampleOut), 0, 0);
    check("R1 initial valid", int'(outValid), 0, 0);
    rst = 1'b0;

    // R1: zero input keeps zero output
    for (int i = 0; i < 5; i++) push(0, "R1 zero input", 0);

    // R5: impulse reaches the output one sample late, scaled by 1/8
    doReset();
    push(8192, "R5 impulse own sample", 0);
    push(0, "R5 impulse next sample", 0);
    check("R5 impulse value 1024", lastOut, 1024, 0);
    for (int i = 0; i < 30; i++) push(0, "R3 R4 impulse tail", TOL);

    // R2/R3/R4 step, ends in positive clamp (R8)
    doReset();
    for (int i = 0; i < 60; i++) push(8192, "R2 R3 R4 step", TOL);
    check("R8 step clamps high", lastOut, 32767, 0);

    // Square wave of +/-1, period 16 samples
    doReset();
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < 8; i++) push(8192, "R3 R4 square", TOL);
      for (int i = 0; i < 8; i++) push(-8192, "R3 R4 square", TOL);
    end

    // Source disabled: input held at zero
    for (int i = 0; i < 20; i++) push(0, "R2 decay", TOL);

    // Random small samples with enable gaps (R7 ignored inputs)
    doReset();
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(3) == 0) idle("R7 gap");
      else begin
        r = int'($urandom_range(4096)) - 2048;
        push(r, "R2 R7 random", TOL);
      end
    end

    // Full scale clamping both ways
    doReset();
    for (int i = 0; i < 40; i++) push(-32768, "R8 negative full scale", TOL);
    check("R8 clamps low", lastOut, -32768, 0);
    doReset();
    for (int i = 0; i < 40; i++) push(32767, "R8 positive full scale", TOL);
    check("R8 clamps high", lastOut, 32767, 0);

    // Reset mid-run clears everything, then zeros stay zero (R1)
    doReset();
    for (int i = 0; i < 4; i++) push(0, "R1 zero after reset", 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule